// File: doc/BRIEF.md
# Two-Channel Serial DAC Register Front End

This block is the digital front end of a two-channel serial-input DAC, modelled synchronously to a fast system clock. The serial clock, active-low chip select, serial data and active-low load inputs arrive as slow pins. Each pin passes through a two-flop synchronizer, and edges are found by comparing each synchronized level with its value one cycle earlier. While chip select is low, a data bit is shifted in on every rising edge of the serial clock. When chip select rises, the most recent eighteen bits are taken as one frame. The first two bits of the frame are an address that picks one channel, both channels or neither. The remaining sixteen bits are the code.

Each channel has two register stages: an input register and a DAC register, which drives the output code bus. The load pin is level-sensitive. While it is low, the DAC registers follow the input registers, so a write reaches the outputs at once. While it is high, writes collect in the input registers and the outputs hold their values until the pin is pulsed low.

A serial clock edge that arrives too close to the chip-select rise is treated as noise and is dropped. A frame that ends before eighteen bits have been counted is thrown away, and a sticky flag records the event.

Top module: `dual_dac_serial_if`

## Requirements
- R1: After reset, both input registers and both DAC outputs hold 16'h8000 and the short-frame flag is 0.
- R2: While chip select is low, the bit on the serial data input is shifted in on each serial clock rising edge. When chip select rises, the frame is taken most significant bit first: address bit 1, address bit 0, then code bits 15 down to 0.
- R3: Address 2'b01 writes the code to channel A only, and address 2'b10 writes it to channel B only.
- R4: Address 2'b11 writes the same code to both channels. Address 2'b00 writes neither channel.
- R5: While the load input is high, a write leaves both DAC outputs unchanged.
- R6: While the load input is low, each DAC output takes its input register's value, including a value written in the same cycle. A low pulse on the load input copies any held input register values to the outputs.
- R7: When more than 18 edges are counted in one chip-select low period, only the last 18 bits shifted in form the frame.
- R8: A frame with fewer than 18 counted edges changes no register and sets a short-frame flag, which stays set until reset.
- R9: A serial clock rising edge seen GUARD_CYC or fewer system cycles before the chip-select rise, or in the same cycle, is not counted as a bit.
- R10: A falling edge of chip select clears the bit counter, so bits from an earlier frame never count toward the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock pin (asynchronous) |
| csn_i | input | 1 | Active-low chip select pin (asynchronous) |
| sdi_i | input | 1 | Serial data pin (asynchronous) |
| ldacn_i | input | 1 | Active-low, level-sensitive load pin (asynchronous) |
| dac_a_o | output | 16 | Channel A DAC register code |
| dac_b_o | output | 16 | Channel B DAC register code |
| short_frame_o | output | 1 | Sticky flag: a frame was discarded as short |

## Verification
The assertions check the register-stage rules on every cycle. The DAC outputs must stay put while the load pin is high, and must track the input registers while it is low. An input register must not change without a write that addresses it. The bit counter must stay capped, it must return to zero after a chip-select fall, and the short-frame flag must stay sticky. Only the bench scenarios can show that the serial order, address decoding, keeping the last eighteen bits of a long frame, dropping a late clock edge, and discarding short frames all work end to end from the pins.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 2;
  localparam int FRAME_W  = ADDR_W + DATA_W;
  localparam int CHANNELS = ADDR_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] code;
  } frame_t;
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
  parameter int FRAME_W   = 18,
  parameter int GUARD_CYC = 4,
  localparam int CNT_W    = $clog2(FRAME_W + 1),
  localparam int GCNT_W   = $clog2(GUARD_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               csn_s,
  input  logic               sdi_s,
  output logic               frame_v_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               short_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0]  FULL  = CNT_W'(FRAME_W);
  localparam logic [GCNT_W-1:0] GLOAD = GCNT_W'(GUARD_CYC - 1);

  logic               sclk_q, csn_q;
  logic [FRAME_W-1:0] sr_q, sr_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               pend_v_q, pend_v_n;
  logic [GCNT_W-1:0]  pend_c_q, pend_c_n;
  logic               pend_b_q, pend_b_n;

  logic sclk_rise, cs_rise, cs_fall, cs_low;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign cs_rise   = csn_s & ~csn_q;
  assign cs_fall   = ~csn_s & csn_q;
  assign cs_low    = ~csn_s & ~csn_q;

  // A captured bit waits GUARD_CYC cycles before it is committed; a
  // chip-select rise during that wait discards it.
  always_comb begin
    sr_n     = sr_q;
    cnt_n    = cnt_q;
    pend_v_n = pend_v_q;
    pend_c_n = pend_c_q;
    pend_b_n = pend_b_q;
    if (pend_v_q && (pend_c_q == '0 || sclk_rise)) begin
      sr_n     = {sr_q[FRAME_W-2:0], pend_b_q};
      pend_v_n = 1'b0;
      if (cnt_q != FULL) cnt_n = cnt_q + 1'b1;
    end else if (pend_v_q) begin
      pend_c_n = pend_c_q - 1'b1;
    end
    if (sclk_rise) begin
      pend_v_n = 1'b1;
      pend_c_n = GLOAD;
      pend_b_n = sdi_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      csn_q     <= 1'b1;
      sr_q      <= '0;
      cnt_q     <= '0;
      pend_v_q  <= 1'b0;
      pend_c_q  <= '0;
      pend_b_q  <= 1'b0;
      frame_v_o <= 1'b0;
      frame_o   <= '0;
      short_o   <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      csn_q     <= csn_s;
      frame_v_o <= 1'b0;
      if (cs_fall) begin
        cnt_q    <= '0;
        pend_v_q <= 1'b0;
      end else if (cs_rise) begin
        pend_v_q <= 1'b0;
        frame_o  <= sr_q;
        if (cnt_q == FULL) frame_v_o <= 1'b1;
        else               short_o   <= 1'b1;
      end else if (cs_low) begin
        sr_q     <= sr_n;
        cnt_q    <= cnt_n;
        pend_v_q <= pend_v_n;
        pend_c_q <= pend_c_n;
        pend_b_q <= pend_b_n;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank #(
  parameter int              DATA_W     = 16,
  parameter int              CHANNELS   = 2,
  parameter logic [DATA_W-1:0] RESET_CODE = 16'h8000
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_v,
  input  logic [CHANNELS-1:0]                wr_sel,
  input  logic [DATA_W-1:0]                  wr_code,
  input  logic                               load_low,
  output logic [CHANNELS-1:0][DATA_W-1:0]    in_q,
  output logic [CHANNELS-1:0][DATA_W-1:0]    dac_q
);
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    logic             hit;
    logic [DATA_W-1:0] in_n;
    assign hit  = wr_v & wr_sel[ch];
    assign in_n = hit ? wr_code : in_q[ch];

    always_ff @(posedge clk) begin
      if (rst) begin
        in_q[ch]  <= RESET_CODE;
        dac_q[ch] <= RESET_CODE;
      end else begin
        in_q[ch] <= in_n;
        if (load_low) dac_q[ch] <= in_n;
      end
    end
  end
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if #(
  parameter int                  SYNC_STAGES = 2,
  parameter int                  GUARD_CYC   = 4,
  parameter logic [15:0]         RESET_CODE  = 16'h8000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk_i,
  input  logic        csn_i,
  input  logic        sdi_i,
  input  logic        ldacn_i,
  output logic [15:0] dac_a_o,
  output logic [15:0] dac_b_o,
  output logic        short_frame_o
);
  import dac_if_pkg::*;
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [3:0] pins_s;
  logic       sclk_s, sdi_s, csn_s, ldacn_s;

  dac_pin_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst(rst),
    .pin_i({ldacn_i, csn_i, sdi_i, sclk_i}),
    .lvl_o(pins_s)
  );
  assign {ldacn_s, csn_s, sdi_s, sclk_s} = pins_s;

  logic               frame_v;
  logic [FRAME_W-1:0] frame_bits;
  logic [CNT_W-1:0]   bit_cnt;
  frame_t             frame;

  dac_frame_shifter #(.FRAME_W(FRAME_W), .GUARD_CYC(GUARD_CYC)) u_shift (
    .clk(clk), .rst(rst),
    .sclk_s(sclk_s), .csn_s(csn_s), .sdi_s(sdi_s),
    .frame_v_o(frame_v), .frame_o(frame_bits),
    .short_o(short_frame_o), .cnt_o(bit_cnt)
  );
  assign frame = frame_t'(frame_bits);

  logic [CHANNELS-1:0][DATA_W-1:0] in_regs, dac_regs;

  dac_reg_bank #(.DATA_W(DATA_W), .CHANNELS(CHANNELS), .RESET_CODE(RESET_CODE)) u_bank (
    .clk(clk), .rst(rst),
    .wr_v(frame_v), .wr_sel(frame.addr), .wr_code(frame.code),
    .load_low(~ldacn_s),
    .in_q(in_regs), .dac_q(dac_regs)
  );

  assign dac_a_o = dac_regs[0];
  assign dac_b_o = dac_regs[1];
endmodule

// File: rtl/dac_if_checker.sv
module dac_if_checker (
  input logic        clk,
  input logic        rst,
  input logic        csn_s,
  input logic        ldacn_s,
  input logic        wr_v,
  input logic [1:0]  wr_sel,
  input logic [4:0]  bit_cnt,
  input logic [15:0] in_a,
  input logic [15:0] in_b,
  input logic [15:0] dac_a,
  input logic [15:0] dac_b,
  input logic        short_flag
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: first cycle out of reset shows midscale and a clear flag
  always @(posedge clk)
    if (rst_d && !rst)
      a_r1_reset_midscale: assert (dac_a == 16'h8000 && dac_b == 16'h8000 && !short_flag);

  a_r5_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    ldacn_s |=> ($stable(dac_a) && $stable(dac_b)));

  a_r6_follow_inputs: assert property (@(posedge clk) disable iff (rst)
    !ldacn_s |=> (dac_a == in_a && dac_b == in_b));

  a_r3_a_only: assert property (@(posedge clk) disable iff (rst)
    (wr_v && wr_sel == 2'b01) |=> $stable(in_b));

  a_r4_none_written: assert property (@(posedge clk) disable iff (rst)
    (!wr_v || wr_sel == 2'b00) |=> ($stable(in_a) && $stable(in_b)));

  a_r7_count_cap: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= 5'd18);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    short_flag |=> short_flag);

  a_r10_count_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(csn_s) |=> bit_cnt == 5'd0);
endmodule

bind dual_dac_serial_if dac_if_checker u_chk (
  .clk(clk), .rst(rst), .csn_s(csn_s), .ldacn_s(ldacn_s),
  .wr_v(frame_v), .wr_sel(frame.addr), .bit_cnt(bit_cnt),
  .in_a(in_regs[0]), .in_b(in_regs[1]),
  .dac_a(dac_regs[0]), .dac_b(dac_regs[1]),
  .short_flag(short_frame_o)
);

// File: tb/tb_dual_dac_serial_if.sv
module tb_dual_dac_serial_if;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_i = 1'b0, csn_i = 1'b1, sdi_i = 1'b0, ldacn_i = 1'b0;
  logic [15:0] dac_a_o, dac_b_o;
  logic short_frame_o;

  always #2 clk = ~clk;

  dual_dac_serial_if dut (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .csn_i(csn_i), .sdi_i(sdi_i),
    .ldacn_i(ldacn_i), .dac_a_o(dac_a_o), .dac_b_o(dac_b_o),
    .short_frame_o(short_frame_o)
  );

  typedef struct {
    logic [15:0] a;
    logic [15:0] b;
    logic        flag;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  // reference model state
  logic [15:0] m_in_a = 16'h8000, m_in_b = 16'h8000;
  logic [15:0] m_out_a = 16'h8000, m_out_b = 16'h8000;
  logic        m_flag = 1'b0;
  logic        m_load_low = 1'b1;

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    cycles(12);
    e.a = m_out_a; e.b = m_out_b; e.flag = m_flag; e.tag = tag;
    exp_q.push_back(e);
    cycles(2);
  endtask

  task automatic model_write(input logic [17:0] fr);
    if (fr[16]) m_in_a = fr[15:0];
    if (fr[17]) m_in_b = fr[15:0];
    if (m_load_low) begin m_out_a = m_in_a; m_out_b = m_in_b; end
  endtask

  // send n bits, MSB first; late adds one extra edge just before the CS rise
  task automatic send(input logic [31:0] bits, input int n, input bit late);
    csn_i = 1'b0;
    cycles(PH);
    for (int i = n - 1; i >= 0; i--) begin
      sclk_i = 1'b0; sdi_i = bits[i];
      cycles(PH);
      sclk_i = 1'b1;
      cycles(PH);
    end
    cycles(PH);
    if (late) begin
      sclk_i = 1'b0; sdi_i = 1'b1;
      cycles(PH);
      sclk_i = 1'b1;
      cycles(1);
    end
    csn_i = 1'b1;
    cycles(PH);
  endtask

  task automatic write(input logic [1:0] addr, input logic [15:0] code, input string tag);
    send({14'd0, addr, code}, 18, 1'b0);
    model_write({addr, code});
    expect_now(tag);
  endtask

  task automatic set_load(input logic low);
    ldacn_i = ~low;
    m_load_low = low;
    if (low) begin m_out_a = m_in_a; m_out_b = m_in_b; end
    cycles(8);
  endtask

  // monitor: compares queued expectations against the ports
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks += 3;
        if (dac_a_o !== e.a) begin
          n_fail++;
          $display("FAIL %s dac_a actual=%h expected=%h", e.tag, dac_a_o, e.a);
        end
        if (dac_b_o !== e.b) begin
          n_fail++;
          $display("FAIL %s dac_b actual=%h expected=%h", e.tag, dac_b_o, e.b);
        end
        if (short_frame_o !== e.flag) begin
          n_fail++;
          $display("FAIL %s short_flag actual=%b expected=%b", e.tag, short_frame_o, e.flag);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cycles(5);
    rst = 1'b0;
    expect_now("R1 reset midscale");

    write(2'b01, 16'h1234, "R2 R3 write channel A");
    write(2'b10, 16'hABCD, "R3 write channel B");
    write(2'b11, 16'h5A5A, "R4 broadcast both");
    write(2'b00, 16'hFFFF, "R4 address 00 no write");

    set_load(1'b0);
    ldacn_i = 1'b1; m_load_low = 1'b0; cycles(8);
    write(2'b01, 16'h1111, "R5 held A while load high");
    write(2'b10, 16'h2222, "R5 held B while load high");
    set_load(1'b1);
    set_load(1'b0);
    ldacn_i = 1'b1; m_load_low = 1'b0; cycles(8);
    expect_now("R6 load pulse copies");
    set_load(1'b1);
    expect_now("R6 load low follows");

    // R7: 22 edges, first four are junk
    send({10'd0, 4'hF, 2'b01, 16'h0F0F}, 22, 1'b0);
    model_write({2'b01, 16'h0F0F});
    expect_now("R7 long frame keeps last 18");

    // R9: extra late edge must be dropped
    send({14'd0, 2'b01, 16'h2468}, 18, 1'b1);
    model_write({2'b01, 16'h2468});
    expect_now("R9 late edge ignored");

    // R8: 17-bit frame discarded, flag set
    send({15'd0, 2'b11, 15'h7FFF}, 17, 1'b0);
    m_flag = 1'b1;
    expect_now("R8 short frame discarded");

    // R10: counter cleared at CS fall, so 10 more bits stay short
    send(32'd0, 10, 1'b0);
    expect_now("R10 counter cleared between frames");

    write(2'b10, 16'h00FF, "R2 frame after short frame");

    cycles(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule